// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the routing configuration of an I/O interrupt controller and presents it to software through two 32-bit registers on a small bus slave port. One register is a selector. The other is a data window through which the selected internal register is read or written. The internal registers are an identifier register, a read-only version register, an arbitration register that mirrors the identifier, and a table of redirection entries. Each entry is 64 bits wide and is reached as two 32-bit halves.

All entries are presented in parallel to the delivery logic on a flat bus. The delivery logic owns two status bits in each entry: the waiting-for-acknowledge bit (remote IRR) and the delivery-in-progress bit. It drives them through per-pin set and clear strobes, and software cannot alter them. Every software write to an entry produces a one-cycle written strobe. When the write alters routing-relevant bits, a second one-cycle change strobe is also produced, so that downstream trigger-mode state can be recomputed.

Top module: `irq_route_regs`

## Requirements
- R1: Only 4-byte accesses (busSize = 4) at byte offset 0x00 (selector) or 0x10 (window) take effect. Any other access changes nothing, and such a read returns 0.
- R2: Read data appears on busRdata one cycle after the read strobe and holds until the next read. The selector stores and returns all 32 written bits. Only its bits 7:0 choose the internal register.
- R3: Selector values 0x10 through 0x10+2*N-1 reach entry (value-0x10)/2. An even value reaches entry bits 31:0 and an odd value reaches entry bits 63:32.
- R4: Index 0x01 (version) reads (N-1) in bits 23:16 ORed with 0x11, which is 0x001F0011 for N = 32. Index 0x02 (arbitration) reads the identifier value. Writes to both indices have no effect.
- R5: Index 0x00 (identifier) keeps only bits 31:24 of written data; all other bits read 0.
- R6: After reset, every entry is 0x0001_0000_0001_0000, with the mask at bit 16 set. The identifier and the selector are 0.
- R7: Software writes never change entry bit 14 (remote IRR) or bit 12 (delivery status). irrSet/dlvSet set those bits and irrClr/dlvClr clear them, one cycle after the strobe; clear wins when both are given.
- R8: A software write that leaves entry bit 15 (trigger, 1 = level) at 0 also clears bit 14 of that entry.
- R9: One cycle after a table write that changes any entry bit other than bit 16 (mask) or bit 13 (polarity), cfgChgPulse is high for one cycle and cfgChgPin gives the entry number.
- R10: One cycle after every table write, entryWrPulse is high for one cycle and entryWrPin gives the entry number.
- R11: Selector values that name no defined register (0x03 to 0x0F and 0x10+2*N and above) read 0 through the window, and writes to them have no effect.
- R12: entryFlat bits [64*i+63 : 64*i] always show entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busSize | input | 3 | Access size in bytes |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irrSet | input | NUM_ENT | Per-entry set of remote IRR |
| irrClr | input | NUM_ENT | Per-entry clear of remote IRR |
| dlvSet | input | NUM_ENT | Per-entry set of delivery status |
| dlvClr | input | NUM_ENT | Per-entry clear of delivery status |
| entryFlat | output | 64*NUM_ENT | All entries, entry i at bits 64*i+63:64*i |
| cfgChgPulse | output | 1 | Routing configuration of an entry changed |
| cfgChgPin | output | PIN_W | Entry number for cfgChgPulse |
| entryWrPulse | output | 1 | An entry was written by software |
| entryWrPin | output | PIN_W | Entry number for entryWrPulse |

## Verification
The bench first runs directed sequences. These walk the selector across the version, arbitration, identifier, reserved and table indices, so that a decode slip between neighbouring indices or between the two halves of an entry is exposed. Mask-only writes are placed against destination and trigger writes to separate the two strobes. Writes carrying ones in the protected bit positions, and trigger-mode flips while remote IRR is held, show whether protection and the edge-mode clear interact correctly.

A seeded random mix then interleaves selector writes, window reads and writes, malformed accesses and hardware strobes. Every result is compared against a bench model, which catches state leaking between entries or accesses acting when they should not.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENT_W   = 64;
  localparam int VEC_LSB = 0;
  localparam int DLV_BIT = 12;
  localparam int POL_BIT = 13;
  localparam int IRR_BIT = 14;
  localparam int TRG_BIT = 15;
  localparam int MSK_BIT = 16;

  localparam logic [ENT_W-1:0] RO_MASK  = (64'd1 << IRR_BIT) | (64'd1 << DLV_BIT);
  localparam logic [ENT_W-1:0] CFG_IGN  = (64'd1 << MSK_BIT) | (64'd1 << POL_BIT);
  localparam logic [ENT_W-1:0] ENT_RST  = 64'h0001_0000_0001_0000;
  localparam logic [31:0]      ID_FIELD = 32'hFF00_0000;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_ID,
    REG_VER,
    REG_ARB,
    REG_TBL
  } regKind_e;

  typedef struct packed {
    logic      selWr;
    logic      selRd;
    logic      winWr;
    logic      winRd;
    logic      badRd;
    regKind_e  kind;
    logic [7:0] pin;
    logic      hi;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_ENT  = 32,
  parameter int ADDR_W   = 8,
  parameter int OFF_SEL  = 'h00,
  parameter int OFF_WIN  = 'h10,
  parameter int IDX_ID   = 'h00,
  parameter int IDX_VER  = 'h01,
  parameter int IDX_ARB  = 'h02,
  parameter int TBL_BASE = 'h10
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        regIndex,
  output ctlStrobe_t        ctl
);

  localparam int TBL_END = TBL_BASE + 2 * NUM_ENT;
  localparam logic [7:0] TBL_BASE8 = 8'(TBL_BASE);

  logic sizeOk;
  logic selHit;
  logic winHit;
  logic [7:0] tblOff;
  int unsigned idxInt;

  always_comb begin
    sizeOk = (busSize == 3'd4);
    selHit = sizeOk && (int'(busAddr) == OFF_SEL);
    winHit = sizeOk && (int'(busAddr) == OFF_WIN);
    idxInt = {24'd0, regIndex};
    tblOff = regIndex - TBL_BASE8;

    ctl       = '0;
    ctl.selWr = busWr && selHit;
    ctl.selRd = busRd && selHit;
    ctl.winWr = busWr && winHit;
    ctl.winRd = busRd && winHit;
    ctl.badRd = busRd && !selHit && !winHit;
    ctl.kind  = REG_NONE;

    if (idxInt == IDX_ID) begin
      ctl.kind = REG_ID;
    end else if (idxInt == IDX_VER) begin
      ctl.kind = REG_VER;
    end else if (idxInt == IDX_ARB) begin
      ctl.kind = REG_ARB;
    end else if (idxInt >= TBL_BASE && idxInt < TBL_END) begin
      ctl.kind = REG_TBL;
      ctl.pin  = {1'b0, tblOff[7:1]};
      ctl.hi   = tblOff[0];
    end
  end

endmodule

// File: rtl/irq_route_data.sv
module irq_route_data
  import irq_route_pkg::*;
#(
  parameter int NUM_ENT = 32,
  parameter int PIN_W   = $clog2(NUM_ENT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               ctl,
  input  logic [31:0]              busWdata,
  input  logic [NUM_ENT-1:0]       irrSet,
  input  logic [NUM_ENT-1:0]       irrClr,
  input  logic [NUM_ENT-1:0]       dlvSet,
  input  logic [NUM_ENT-1:0]       dlvClr,
  output logic [7:0]               regIndex,
  output logic [31:0]              busRdata,
  output logic [NUM_ENT*ENT_W-1:0] entryFlat,
  output logic                     cfgChgPulse,
  output logic [PIN_W-1:0]         cfgChgPin,
  output logic                     entryWrPulse,
  output logic [PIN_W-1:0]         entryWrPin
);

  localparam logic [31:0] VER_VAL = (32'(NUM_ENT - 1) << 16) | 32'h11;

  logic [ENT_W-1:0] tbl     [NUM_ENT];
  logic [ENT_W-1:0] nextEnt [NUM_ENT];
  logic [31:0]      selReg;
  logic [31:0]      idReg;

  logic             tblWr;
  logic [PIN_W-1:0] wPin;
  logic [ENT_W-1:0] curEnt;
  logic [ENT_W-1:0] laneMask;
  logic [ENT_W-1:0] data64;
  logic [ENT_W-1:0] swEnt;
  logic [ENT_W-1:0] chgBits;
  logic [31:0]      rdVal;
  logic             rdAny;

  assign regIndex = selReg[7:0];
  assign tblWr    = ctl.winWr && (ctl.kind == REG_TBL);
  assign wPin     = ctl.pin[PIN_W-1:0];
  assign rdAny    = ctl.selRd || ctl.winRd || ctl.badRd;

  // Software merge for the addressed entry.
  always_comb begin
    curEnt   = tbl[wPin];
    laneMask = ctl.hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
    data64   = ctl.hi ? {busWdata, 32'h0} : {32'h0, busWdata};
    swEnt    = (curEnt & (~laneMask | RO_MASK)) | (data64 & laneMask & ~RO_MASK);
    if (!swEnt[TRG_BIT]) swEnt[IRR_BIT] = 1'b0;
    chgBits  = (curEnt ^ swEnt) & ~CFG_IGN;
  end

  // Per-entry next state: software merge, then hardware strobes.
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      logic hitI;
      hitI = tblWr && (wPin == PIN_W'(i));
      nextEnt[i] = hitI ? swEnt : tbl[i];
      nextEnt[i][IRR_BIT] = (nextEnt[i][IRR_BIT] | irrSet[i]) & ~irrClr[i];
      nextEnt[i][DLV_BIT] = (nextEnt[i][DLV_BIT] | dlvSet[i]) & ~dlvClr[i];
      if (hitI && !nextEnt[i][TRG_BIT]) nextEnt[i][IRR_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) tbl[i] <= ENT_RST;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) tbl[i] <= nextEnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
    end else begin
      if (ctl.selWr) selReg <= busWdata;
      if (ctl.winWr && ctl.kind == REG_ID) idReg <= busWdata & ID_FIELD;
    end
  end

  always_comb begin
    rdVal = '0;
    if (ctl.selRd) begin
      rdVal = selReg;
    end else if (ctl.winRd) begin
      case (ctl.kind)
        REG_ID:  rdVal = idReg;
        REG_VER: rdVal = VER_VAL;
        REG_ARB: rdVal = idReg;
        REG_TBL: rdVal = ctl.hi ? tbl[wPin][63:32] : tbl[wPin][31:0];
        default: rdVal = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata     <= '0;
      cfgChgPulse  <= 1'b0;
      cfgChgPin    <= '0;
      entryWrPulse <= 1'b0;
      entryWrPin   <= '0;
    end else begin
      if (rdAny) busRdata <= rdVal;
      entryWrPulse <= tblWr;
      cfgChgPulse  <= tblWr && (|chgBits);
      if (tblWr) begin
        entryWrPin <= wPin;
        cfgChgPin  <= wPin;
      end
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : gFlat
    assign entryFlat[g*ENT_W +: ENT_W] = tbl[g];

    assert_dlv_sw_proof_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!dlvSet[g] && !dlvClr[g]) |=> $stable(tbl[g][DLV_BIT]));

    assert_irr_sw_proof_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!irrSet[g] && !irrClr[g] && !(tblWr && wPin == PIN_W'(g)))
        |=> $stable(tbl[g][IRR_BIT]));

    assert_edge_drops_irr_R8: assert property (@(posedge clk) disable iff (!rstN)
      (tblWr && wPin == PIN_W'(g)) |=> !(tbl[g][IRR_BIT] && !tbl[g][TRG_BIT]));
  end

  assert_chg_implies_wr_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgChgPulse |-> (entryWrPulse && cfgChgPin == entryWrPin));

  assert_wr_pulse_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    entryWrPulse |-> ($past(ctl.winWr) && $past(ctl.kind) == REG_TBL));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_ENT = 32,
  parameter int ADDR_W  = 8,
  localparam int PIN_W  = $clog2(NUM_ENT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [2:0]               busSize,
  input  logic                     busRd,
  input  logic                     busWr,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  input  logic [NUM_ENT-1:0]       irrSet,
  input  logic [NUM_ENT-1:0]       irrClr,
  input  logic [NUM_ENT-1:0]       dlvSet,
  input  logic [NUM_ENT-1:0]       dlvClr,
  output logic [NUM_ENT*ENT_W-1:0] entryFlat,
  output logic                     cfgChgPulse,
  output logic [PIN_W-1:0]         cfgChgPin,
  output logic                     entryWrPulse,
  output logic [PIN_W-1:0]         entryWrPin
);

  ctlStrobe_t ctl;
  logic [7:0] regIndex;

  irq_route_ctrl #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busRd    (busRd),
    .busWr    (busWr),
    .regIndex (regIndex),
    .ctl      (ctl)
  );

  irq_route_data #(.NUM_ENT(NUM_ENT), .PIN_W(PIN_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .busWdata     (busWdata),
    .irrSet       (irrSet),
    .irrClr       (irrClr),
    .dlvSet       (dlvSet),
    .dlvClr       (dlvClr),
    .regIndex     (regIndex),
    .busRdata     (busRdata),
    .entryFlat    (entryFlat),
    .cfgChgPulse  (cfgChgPulse),
    .cfgChgPin    (cfgChgPin),
    .entryWrPulse (entryWrPulse),
    .entryWrPin   (entryWrPin)
  );

  assert_stray_read_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(busRd && !(busSize == 3'd4 && (int'(busAddr) == 'h00 || int'(busAddr) == 'h10)))
      |-> busRdata == 32'd0);

endmodule

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;

  localparam int N = 32;
  localparam logic [31:0] VER_EXP = 32'h001F_0011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [2:0] busSize = '0;
  logic busRd = 1'b0;
  logic busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] irrSet = '0, irrClr = '0, dlvSet = '0, dlvClr = '0;
  logic [N*64-1:0] entryFlat;
  logic cfgChgPulse, entryWrPulse;
  logic [4:0] cfgChgPin, entryWrPin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] mTbl [N];
  logic [31:0] mId, mSel;

  always #4 clk = ~clk;

  irq_route_regs i_irq_route_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .irrSet(irrSet), .irrClr(irrClr), .dlvSet(dlvSet), .dlvClr(dlvClr),
    .entryFlat(entryFlat), .cfgChgPulse(cfgChgPulse), .cfgChgPin(cfgChgPin),
    .entryWrPulse(entryWrPulse), .entryWrPin(entryWrPin)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] merge(input logic [63:0] old, input logic hi, input logic [31:0] d);
    logic [63:0] r;
    r = old;
    if (hi) r[63:32] = d; else r[31:0] = d;
    r[14] = old[14];
    r[12] = old[12];
    if (!r[15]) r[14] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] idx);
    if (idx == 8'h00 || idx == 8'h02) return mId;
    if (idx == 8'h01) return VER_EXP;
    if (idx >= 8'h10 && idx < 8'h50) begin
      logic [7:0] o;
      o = idx - 8'h10;
      return o[0] ? mTbl[o[7:1]][63:32] : mTbl[o[7:1]][31:0];
    end
    return 32'd0;
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = s; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = s; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  // Model-tracking window write with strobe checks
  task automatic winWrite(input logic [31:0] d, input string req);
    logic [7:0] idx;
    logic isTbl;
    logic [4:0] p;
    logic [63:0] nv;
    logic expChg;
    idx = mSel[7:0];
    isTbl = (idx >= 8'h10 && idx < 8'h50);
    p = 5'((idx - 8'h10) >> 1);
    expChg = 1'b0;
    if (isTbl) begin
      nv = merge(mTbl[p], idx[0], d);
      expChg = |((nv ^ mTbl[p]) & ~64'h12000);
      mTbl[p] = nv;
    end else if (idx == 8'h00) begin
      mId = d & 32'hFF00_0000;
    end
    busWrite(8'h10, 3'd4, d);
    check({req, " R10 entryWrPulse"}, 64'(entryWrPulse), 64'(isTbl));
    check({req, " R9 cfgChgPulse"}, 64'(cfgChgPulse), 64'(expChg));
    if (isTbl) check({req, " R10 entryWrPin"}, 64'(entryWrPin), 64'(p));
    if (expChg) check({req, " R9 cfgChgPin"}, 64'(cfgChgPin), 64'(p));
  endtask

  task automatic selWrite(input logic [31:0] d);
    mSel = d;
    busWrite(8'h00, 3'd4, d);
  endtask

  task automatic winCheck(input string req);
    logic [31:0] r;
    busRead(8'h10, 3'd4, r);
    check(req, 64'(r), 64'(expRead(mSel[7:0])));
  endtask

  task automatic entriesCheck(input string req);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < N; i++) if (entryFlat[i*64 +: 64] !== mTbl[i]) bad = 1'b1;
    check({req, " R12 entryFlat"}, 64'(bad), 64'd0);
  endtask

  task automatic hwStrobe(input int p, input bit iS, input bit iC, input bit dS, input bit dC);
    @(negedge clk);
    irrSet[p] = iS; irrClr[p] = iC; dlvSet[p] = dS; dlvClr[p] = dC;
    mTbl[p][14] = (mTbl[p][14] | iS) & ~iC;
    mTbl[p][12] = (mTbl[p][12] | dS) & ~dC;
    @(negedge clk);
    irrSet = '0; irrClr = '0; dlvSet = '0; dlvClr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) mTbl[i] = 64'h0001_0000_0001_0000;
    mId = '0; mSel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    check("R6 rdata after reset", 64'(busRdata), 64'd0);
    entriesCheck("R6 reset");
    busRead(8'h00, 3'd4, r);
    check("R6 selector reset", 64'(r), 64'd0);

    // Version / arbitration / ID
    selWrite(32'h1);
    winCheck("R4 version");
    winWrite(32'hFFFF_FFFF, "R4 ver write");
    winCheck("R4 version after write");
    selWrite(32'h0);
    winWrite(32'hABCD_EF12, "R5 id write");
    winCheck("R5 id masked");
    check("R5 id value", 64'(mId), 64'h0000_0000_AB00_0000);
    selWrite(32'h2);
    winWrite(32'h1234_5678, "R4 arb write");
    winCheck("R4 arb mirrors id");

    // Selector readback, low bits decode
    selWrite(32'h1234_5610);
    busRead(8'h00, 3'd4, r);
    check("R2 selector full readback", 64'(r), 64'h1234_5610);
    winCheck("R3 entry0 low");
    check("R2 read holds", 64'(busRdata), 64'h0001_0000);

    // Destination write to entry 5 high
    selWrite(32'h10 + 2*5 + 1);
    winWrite(32'hFF00_0000, "R3 dest e5");
    entriesCheck("R3 e5 high");
    // Mask-only change -> no cfg pulse
    selWrite(32'h10 + 2*5);
    winWrite(32'h0000_0000, "R9 mask only");
    // Polarity-only change
    winWrite(32'h0000_2000, "R9 polarity only");
    winCheck("R3 e5 low");

    // Remote IRR protection and edge clear
    selWrite(32'h10 + 2*3);
    winWrite(32'h0000_8030, "R9 level e3");
    hwStrobe(3, 1, 0, 1, 0);
    entriesCheck("R7 hw set");
    winWrite(32'h0000_8030, "R7 rewrite");
    check("R7 irr kept", 64'(entryFlat[3*64+14]), 64'd1);
    check("R7 dlv kept", 64'(entryFlat[3*64+12]), 64'd1);
    winWrite(32'h0000_0030, "R8 to edge");
    check("R8 irr cleared", 64'(entryFlat[3*64+14]), 64'd0);
    hwStrobe(3, 0, 0, 1, 1);
    check("R7 clear wins", 64'(entryFlat[3*64+12]), 64'd0);
    selWrite(32'h10 + 2*7);
    winWrite(32'h0000_D000, "R7 sw ones");
    check("R7 sw cannot set irr", 64'(entryFlat[7*64+14]), 64'd0);
    check("R7 sw cannot set dlv", 64'(entryFlat[7*64+12]), 64'd0);

    // Malformed accesses
    busWrite(8'h10, 3'd2, 32'hDEAD_BEEF);
    busWrite(8'h00, 3'd1, 32'h0000_0001);
    entriesCheck("R1 bad writes");
    busRead(8'h00, 3'd4, r);
    check("R1 selector unchanged", 64'(r), 64'(mSel));
    busRead(8'h04, 3'd4, r);
    check("R1 bad offset read", 64'(r), 64'd0);
    busRead(8'h10, 3'd2, r);
    check("R1 bad size read", 64'(r), 64'd0);

    // Undefined indices
    selWrite(32'h05); winCheck("R11 idx 05");
    winWrite(32'hFFFF_FFFF, "R11 idx 05 write");
    selWrite(32'h0F); winCheck("R11 idx 0F");
    selWrite(32'h50); winCheck("R11 idx 50");
    selWrite(32'h4F); winCheck("R3 last entry high");
    entriesCheck("R11 no effect");

    // Random mix
    for (int it = 0; it < 800; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: begin
          if ($urandom_range(0, 9) < 7) selWrite(32'h10 + $urandom_range(0, 63));
          else selWrite($urandom);
        end
        2, 3, 4: winWrite($urandom & 32'hFFFF_DFFF | ($urandom_range(0,1) << 13), "RND R3");
        5, 6: winCheck("RND R3 read");
        7: begin
          busRead(8'($urandom_range(1, 15)), 3'd4, r);
          check("RND R1 bad read", 64'(r), 64'd0);
        end
        default: hwStrobe($urandom_range(0, N-1), 1'($urandom), 1'($urandom),
                          1'($urandom), 1'($urandom));
      endcase
      if (it % 8 == 0) entriesCheck("RND");
    end
    entriesCheck("RND final");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule